// File: doc/BRIEF.md
# Programmable Device Bus Cycle Sequencer

This block runs single and burst transfers to slow peripherals on a local bus: memories, flash, register files. One clock pulse on the request input starts a cycle. The sequencer then drives an active-low chip select, an active-low write strobe or read strobe, and a 3-bit burst address that is separate from the shared address/data lines. A completion pulse ends the cycle. Address decoding, byte packing and the host-side protocol are handled elsewhere. That outside logic presents the chosen timing fields along with the request.

Every cycle takes its phase lengths from five timing fields, which are latched when the request is accepted. A write opens with a lead interval before the first write pulse. Each beat is one write pulse of programmable width, and a programmable high gap separates the pulses. A read waits a programmable access time before capturing the first beat, and a second access time before each later beat. The device can slow the cycle through an active-high ready input. Ready is looked at only at one specific clock of the write pulse and at one specific clock of each read access. Everywhere else it has no effect.

Top module: `devbus_seq`

## Requirements
- R1: While reset is held and after reset releases, cs_n, we_n and re_n are 1, done and rd_strobe are 0, and burst_adr is 0.
- R2: A write request accepted at clock edge E0 drives cs_n low from E0 on. we_n first goes low max(tm_wr_lead,1) clocks after E0, and each write pulse stays low for max(tm_wr_act,1) clocks when ready is high.
- R3: In a write burst, we_n stays high for max(tm_wr_gap,1) clocks between pulses and cs_n stays low without a break from E0 to the end of the last pulse. burst_adr is 0 during the first pulse and goes up by one at the end of each pulse.
- R4: For a read accepted at E0, re_n is low from E0 on. The first beat is captured max(tm_rd_first,1) clocks after E0 and each later beat max(tm_rd_next,1) clocks after the previous one. At each capture, dev_rdata is registered into rd_data and rd_strobe is 1 for exactly the next clock.
- R5: req_beats holds the beat count minus one (0 means 1 beat, 7 means 8 beats). During a read, burst_adr equals the index of the beat being accessed, starting at 0.
- R6: During a write, dev_ready is sampled only at the edge that ends the last clock of a write pulse. Each low sample there lengthens that pulse by one clock.
- R7: During a read access of length L, dev_ready is sampled at the edge ending clock L-1 of the access (when L is at least 2), or at the capture edge itself (when L is 1). Each low sample there delays the capture by one clock.
- R8: dev_ready has no effect during the write lead interval, the write gap, the non-sampling clocks of a write pulse or of a read access, and the capture edge of a read access longer than one clock.
- R9: A timing field of 0 behaves exactly like a field of 1.
- R10: After the last beat, cs_n returns high and done is 1 for exactly one clock. req_valid is ignored during that clock, and a request held high is accepted on the following clock.
- R11: Direction, beat count and all timing fields are captured at acceptance. Changing them during a cycle does not alter that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start of a cycle (address strobe), accepted when idle |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_beats | input | 3 | Number of beats minus one |
| tm_wr_lead | input | TW | Clocks from acceptance to the first write pulse |
| tm_wr_act | input | TW | Write pulse low width in clocks |
| tm_wr_gap | input | TW | Write high time between pulses in clocks |
| tm_rd_first | input | TW | Access time to the first read beat in clocks |
| tm_rd_next | input | TW | Access time to each later read beat in clocks |
| dev_ready | input | 1 | Device ready, active high, sampled only at stretch points |
| dev_rdata | input | DW | Read data from the device |
| cs_n | output | 1 | Chip select, active low |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| burst_adr | output | 3 | Beat address within the burst |
| rd_data | output | DW | Most recently captured read word |
| rd_strobe | output | 1 | One-clock pulse marking new rd_data |
| done | output | 1 | One-clock cycle completion pulse |

## Verification
The hardest thing to reach from the ports is the single clock at which ready matters. That clock sits at a different offset inside each phase, and for reads it moves to the capture edge when the access length is one. The stimulus drives ready from a per-edge bit mask counted from the acceptance edge. It holds ready low across whole phases and low at exactly the sampling edge for several clocks, so that stretches and ignored windows show up as exact cycle counts. The timing inputs are also overwritten just after acceptance, so any field that is read late instead of latched changes the measured lengths.

// File: rtl/devbus_pkg.sv
package devbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_LEAD   = 3'd1,
    PH_WACT   = 3'd2,
    PH_WGAP   = 3'd3,
    PH_RFIRST = 3'd4,
    PH_RNEXT  = 3'd5,
    PH_FINISH = 3'd6
  } phase_t;

endpackage

// File: rtl/devbus_tm_latch.sv
module devbus_tm_latch #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] tm_wr_lead,
  input  logic [TW-1:0] tm_wr_act,
  input  logic [TW-1:0] tm_wr_gap,
  input  logic [TW-1:0] tm_rd_first,
  input  logic [TW-1:0] tm_rd_next,
  output logic [TW-1:0] len_lead,
  output logic [TW-1:0] len_act,
  output logic [TW-1:0] len_gap,
  output logic [TW-1:0] len_first,
  output logic [TW-1:0] len_next
);

  localparam logic [TW-1:0] ONE = TW'(1);

  // a zero field is promoted to one clock
  function automatic logic [TW-1:0] at_least_one(input logic [TW-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      len_lead  <= ONE;
      len_act   <= ONE;
      len_gap   <= ONE;
      len_first <= ONE;
      len_next  <= ONE;
    end else if (load) begin
      len_lead  <= at_least_one(tm_wr_lead);
      len_act   <= at_least_one(tm_wr_act);
      len_gap   <= at_least_one(tm_wr_gap);
      len_first <= at_least_one(tm_rd_first);
      len_next  <= at_least_one(tm_rd_next);
    end
  end

endmodule

// File: rtl/devbus_burst_ctr.sv
module devbus_burst_ctr #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  input  logic [AW-1:0] beats_m1,
  output logic [AW-1:0] badr,
  output logic          last_beat
);

  logic [AW-1:0] limit;

  always_ff @(posedge clk) begin
    if (rst) begin
      badr  <= '0;
      limit <= '0;
    end else if (clr) begin
      badr  <= '0;
      limit <= beats_m1;
    end else if (adv) begin
      badr  <= badr + AW'(1);
    end
  end

  assign last_beat = (badr == limit);

  // R5
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr) |=> (badr == $past(badr) + AW'(1)));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> $stable(badr));

endmodule

// File: rtl/devbus_rd_cap.sv
module devbus_rd_cap #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] rd_data,
  output logic          rd_strobe
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data   <= '0;
      rd_strobe <= 1'b0;
    end else begin
      rd_strobe <= cap;
      if (cap) rd_data <= din;
    end
  end

endmodule

// File: rtl/devbus_phase_fsm.sv
module devbus_phase_fsm
  import devbus_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [TW-1:0] len_lead,
  input  logic [TW-1:0] len_act,
  input  logic [TW-1:0] len_gap,
  input  logic [TW-1:0] len_first,
  input  logic [TW-1:0] len_next,
  input  logic          dev_ready,
  input  logic          last_beat,
  output logic          start,
  output logic          advance,
  output logic          capture,
  output logic          cs_n,
  output logic          we_n,
  output logic          re_n,
  output logic          done
);

  localparam logic [TW-1:0] ONE = TW'(1);
  localparam logic [TW-1:0] TWO = TW'(2);

  phase_t        phase, phase_d;
  logic [TW-1:0] cnt, cnt_d;
  logic [TW-1:0] rd_len, rd_samp;
  logic          in_read;

  assign in_read = (phase == PH_RFIRST) || (phase == PH_RNEXT);
  assign rd_len  = (phase == PH_RFIRST) ? len_first : len_next;
  // ready point: one clock before capture, or the capture edge for 1-clock access
  assign rd_samp = (rd_len == ONE) ? '0 : rd_len - TWO;

  always_comb begin
    phase_d = phase;
    cnt_d   = cnt + ONE;
    start   = 1'b0;
    advance = 1'b0;
    capture = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        cnt_d = '0;
        if (req_valid) begin
          start   = 1'b1;
          phase_d = req_write ? PH_LEAD : PH_RFIRST;
        end
      end
      PH_LEAD: begin
        if (cnt == len_lead - ONE) begin
          phase_d = PH_WACT;
          cnt_d   = '0;
        end
      end
      PH_WACT: begin
        if (cnt == len_act - ONE) begin
          if (!dev_ready) begin
            cnt_d = cnt;
          end else if (last_beat) begin
            phase_d = PH_FINISH;
            cnt_d   = '0;
          end else begin
            phase_d = PH_WGAP;
            advance = 1'b1;
            cnt_d   = '0;
          end
        end
      end
      PH_WGAP: begin
        if (cnt == len_gap - ONE) begin
          phase_d = PH_WACT;
          cnt_d   = '0;
        end
      end
      PH_RFIRST, PH_RNEXT: begin
        if ((cnt == rd_samp) && !dev_ready) begin
          cnt_d = cnt;
        end else if (cnt == rd_len - ONE) begin
          capture = 1'b1;
          cnt_d   = '0;
          if (last_beat) begin
            phase_d = PH_FINISH;
          end else begin
            phase_d = PH_RNEXT;
            advance = 1'b1;
          end
        end
      end
      PH_FINISH: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      cs_n  <= 1'b1;
      we_n  <= 1'b1;
      re_n  <= 1'b1;
      done  <= 1'b0;
    end else begin
      phase <= phase_d;
      cnt   <= cnt_d;
      cs_n  <= (phase_d == PH_IDLE) || (phase_d == PH_FINISH);
      we_n  <= (phase_d != PH_WACT);
      re_n  <= !((phase_d == PH_RFIRST) || (phase_d == PH_RNEXT));
      done  <= (phase_d == PH_FINISH);
    end
  end

  // R6
  wr_stretch_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WACT && cnt == len_act - ONE && !dev_ready)
      |=> (phase == PH_WACT && !we_n));

  // R7
  rd_stretch_chk: assert property (@(posedge clk) disable iff (rst)
    (in_read && cnt == rd_samp && !dev_ready) |=> ($stable(cnt) && !re_n));

  // R10
  finish_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FINISH) |=> (phase == PH_IDLE && cs_n && !done));

endmodule

// File: rtl/devbus_seq.sv
module devbus_seq #(
  parameter int DW        = 16,
  parameter int TW        = 4,
  parameter int MAX_BEATS = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  input  logic                         req_write,
  input  logic [$clog2(MAX_BEATS)-1:0] req_beats,
  input  logic [TW-1:0]                tm_wr_lead,
  input  logic [TW-1:0]                tm_wr_act,
  input  logic [TW-1:0]                tm_wr_gap,
  input  logic [TW-1:0]                tm_rd_first,
  input  logic [TW-1:0]                tm_rd_next,
  input  logic                         dev_ready,
  input  logic [DW-1:0]                dev_rdata,
  output logic                         cs_n,
  output logic                         we_n,
  output logic                         re_n,
  output logic [$clog2(MAX_BEATS)-1:0] burst_adr,
  output logic [DW-1:0]                rd_data,
  output logic                         rd_strobe,
  output logic                         done
);

  localparam int AW = $clog2(MAX_BEATS);

  logic          start, advance, capture, last_beat;
  logic [TW-1:0] len_lead, len_act, len_gap, len_first, len_next;

  devbus_tm_latch #(.TW(TW)) u_tm (
    .clk(clk), .rst(rst), .load(start),
    .tm_wr_lead(tm_wr_lead), .tm_wr_act(tm_wr_act), .tm_wr_gap(tm_wr_gap),
    .tm_rd_first(tm_rd_first), .tm_rd_next(tm_rd_next),
    .len_lead(len_lead), .len_act(len_act), .len_gap(len_gap),
    .len_first(len_first), .len_next(len_next)
  );

  devbus_burst_ctr #(.AW(AW)) u_burst (
    .clk(clk), .rst(rst), .clr(start), .adv(advance),
    .beats_m1(req_beats), .badr(burst_adr), .last_beat(last_beat)
  );

  devbus_phase_fsm #(.TW(TW)) u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .len_lead(len_lead), .len_act(len_act), .len_gap(len_gap),
    .len_first(len_first), .len_next(len_next),
    .dev_ready(dev_ready), .last_beat(last_beat),
    .start(start), .advance(advance), .capture(capture),
    .cs_n(cs_n), .we_n(we_n), .re_n(re_n), .done(done)
  );

  devbus_rd_cap #(.DW(DW)) u_cap (
    .clk(clk), .rst(rst), .cap(capture), .din(dev_rdata),
    .rd_data(rd_data), .rd_strobe(rd_strobe)
  );

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4
  strobe_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |-> $past(!re_n));

  // R3
  adr_steady_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (!we_n && $past(!we_n)) |-> $stable(burst_adr));

endmodule

// File: tb/sim_devbus_seq.sv
module sim_devbus_seq;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]  req_beats = '0;
  logic [3:0]  tm_wr_lead = '0, tm_wr_act = '0, tm_wr_gap = '0;
  logic [3:0]  tm_rd_first = '0, tm_rd_next = '0;
  logic        dev_ready = 1'b1;
  logic [15:0] dev_rdata;
  logic        cs_n, we_n, re_n, rd_strobe, done;
  logic [2:0]  burst_adr;
  logic [15:0] rd_data;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // results of the last measured cycle
  int m_cs, m_we, m_re, m_done_at, m_first_we, m_wn, m_cn, m_first_cap;
  int m_wbadr[8];
  logic [15:0] m_capd[8];
  logic m_after_cs, m_after_done;

  always #(CLK_P/2) clk = ~clk;

  // device model: word depends on the beat address
  assign dev_rdata = 16'hC300 + {13'd0, burst_adr};

  devbus_seq u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_beats(req_beats), .tm_wr_lead(tm_wr_lead), .tm_wr_act(tm_wr_act),
    .tm_wr_gap(tm_wr_gap), .tm_rd_first(tm_rd_first), .tm_rd_next(tm_rd_next),
    .dev_ready(dev_ready), .dev_rdata(dev_rdata), .cs_n(cs_n), .we_n(we_n),
    .re_n(re_n), .burst_adr(burst_adr), .rd_data(rd_data),
    .rd_strobe(rd_strobe), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // rmask bit j = dev_ready at the j-th edge after acceptance
  task automatic run_cycle(input bit wr, input logic [3:0] f_lead, f_act, f_gap,
                           f_first, f_next, input logic [2:0] bm1,
                           input logic [63:0] rmask);
    logic prev_we;
    m_cs = 0; m_we = 0; m_re = 0; m_done_at = -1; m_first_we = -1;
    m_wn = 0; m_cn = 0; m_first_cap = -1; prev_we = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_beats = bm1; dev_ready = 1'b1;
    tm_wr_lead = f_lead; tm_wr_act = f_act; tm_wr_gap = f_gap;
    tm_rd_first = f_first; tm_rd_next = f_next;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (k == 0) begin
        // R11: scramble the request fields once accepted
        req_valid = 1'b0; req_write = ~wr; req_beats = ~bm1;
        tm_wr_lead = 4'hF; tm_wr_act = 4'hF; tm_wr_gap = 4'hF;
        tm_rd_first = 4'hF; tm_rd_next = 4'hF;
      end
      if (!cs_n) m_cs++;
      if (!re_n) m_re++;
      if (!we_n) begin
        m_we++;
        if (prev_we) begin
          if (m_first_we < 0) m_first_we = k;
          if (m_wn < 8) m_wbadr[m_wn] = int'(burst_adr);
          m_wn++;
        end
      end
      prev_we = we_n;
      if (rd_strobe) begin
        if (m_first_cap < 0) m_first_cap = k;
        if (m_cn < 8) m_capd[m_cn] = rd_data;
        m_cn++;
      end
      if (done) begin
        m_done_at = k;
        break;
      end
      dev_ready = (k + 1 < 64) ? rmask[k+1] : 1'b1;
    end
    dev_ready = 1'b1;
    @(negedge clk);
    m_after_cs = cs_n; m_after_done = done;
  endtask

  task automatic t_reset();
    // R1
    chk(cs_n && we_n && re_n, "R1 strobes idle high", {cs_n, we_n, re_n}, 7);
    chk(!done && !rd_strobe && burst_adr == 0, "R1 done/strobe/adr clear",
        {done, rd_strobe, burst_adr}, 0);
  endtask

  task automatic t_single_write();
    run_cycle(1, 4'd3, 4'd2, 4'd5, 4'd1, 4'd1, 3'd0, '1);
    chk(m_first_we == 3, "R2 lead before write pulse", m_first_we, 3);
    chk(m_we == 2, "R2 write pulse width", m_we, 2);
    chk(m_done_at == 5, "R11 latched timing sets done point", m_done_at, 5);
    chk(m_cs == 5, "R2 chip select span", m_cs, 5);
    chk(m_after_cs && !m_after_done, "R10 done one clock then idle",
        {m_after_cs, m_after_done}, 2);
  endtask

  task automatic t_burst_write();
    run_cycle(1, 4'd1, 4'd2, 4'd3, 4'd1, 4'd1, 3'd3, '1);
    chk(m_wn == 4, "R5 four write pulses", m_wn, 4);
    chk(m_we == 8, "R3 total write low", m_we, 8);
    chk(m_cs == 18, "R3 chip select continuous over gaps", m_cs, 18);
    chk(m_done_at == 18, "R3 done after last pulse", m_done_at, 18);
    for (int i = 0; i < 4; i++)
      chk(m_wbadr[i] == i, "R3 burst address per pulse", m_wbadr[i], i);
  endtask

  task automatic t_single_read();
    run_cycle(0, 4'd1, 4'd1, 4'd1, 4'd4, 4'd2, 3'd0, '1);
    chk(m_re == 4, "R4 read strobe length", m_re, 4);
    chk(m_first_cap == 4, "R4 capture strobe timing", m_first_cap, 4);
    chk(m_cn == 1 && m_capd[0] == 16'hC300, "R4 captured word",
        int'(m_capd[0]), 16'hC300);
    chk(m_done_at == 4, "R10 read done point", m_done_at, 4);
  endtask

  task automatic t_burst_read();
    run_cycle(0, 4'd1, 4'd1, 4'd1, 4'd2, 4'd3, 3'd7, '1);
    chk(m_cn == 8, "R5 eight read beats", m_cn, 8);
    chk(m_first_cap == 2, "R4 first access time", m_first_cap, 2);
    chk(m_done_at == 23, "R4 next access time", m_done_at, 23);
    for (int i = 0; i < 8; i++)
      chk(m_capd[i] == 16'hC300 + 16'(i), "R5 beat address at capture",
          int'(m_capd[i]), 16'hC300 + i);
  endtask

  task automatic t_write_ready();
    // low over lead and early pulse (ignored) and at the last pulse clock x3
    run_cycle(1, 4'd2, 4'd3, 4'd1, 4'd1, 4'd1, 3'd0, ~64'h0FE);
    chk(m_first_we == 2, "R8 ready ignored in lead", m_first_we, 2);
    chk(m_we == 6, "R6 pulse stretched by three", m_we, 6);
    chk(m_done_at == 8, "R6 done after stretch", m_done_at, 8);
  endtask

  task automatic t_read_ready();
    // edges 1,2 ignored, 3,4 stall first access; edge 9 is a capture edge (ignored)
    run_cycle(0, 4'd1, 4'd1, 4'd1, 4'd4, 4'd3, 3'd1, ~64'h21E);
    chk(m_first_cap == 6, "R7 first access stretched by two", m_first_cap, 6);
    chk(m_done_at == 9, "R8 ready ignored at capture edge", m_done_at, 9);
    chk(m_cn == 2 && m_capd[1] == 16'hC301, "R7 second beat word",
        int'(m_capd[1]), 16'hC301);
  endtask

  task automatic t_read_ready_short();
    // zero first field: one-clock access, ready sampled at the capture edge
    run_cycle(0, 4'd1, 4'd1, 4'd1, 4'd0, 4'd1, 3'd1, ~64'h16);
    chk(m_first_cap == 3, "R7 one-clock access stalled at capture", m_first_cap, 3);
    chk(m_done_at == 5, "R9 zero access field as one", m_done_at, 5);
  endtask

  task automatic t_zero_write();
    run_cycle(1, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 3'd1, '1);
    chk(m_first_we == 1, "R9 zero lead", m_first_we, 1);
    chk(m_we == 2, "R9 zero pulse width", m_we, 2);
    chk(m_done_at == 4, "R9 zero gap", m_done_at, 4);
  endtask

  task automatic t_held_request();
    int d;
    d = -1;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_beats = 3'd0;
    tm_wr_lead = 4'd1; tm_wr_act = 4'd1; tm_wr_gap = 4'd1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (done) begin d = k; break; end
    end
    chk(d == 2, "R10 held request does not restart cycle", d, 2);
    @(negedge clk);
    chk(cs_n && !done, "R10 request ignored in done clock", {cs_n, done}, 2);
    @(negedge clk);
    chk(!cs_n, "R10 request accepted on next clock", cs_n, 0);
    req_valid = 1'b0;
    d = -1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (done) begin d = k; break; end
    end
    chk(d >= 0, "R10 second cycle completes", d, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single_write();
    t_burst_write();
    t_single_read();
    t_burst_read();
    t_write_ready();
    t_read_ready();
    t_read_ready_short();
    t_zero_write();
    t_held_request();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule